// File: doc/BRIEF.md
# Indexed Range Stack

This block is a shallow register-file stack for an in-place sorting engine. Each entry holds three array indices: the lower bound of a sub-range, its upper bound, and the position where its pivot ended up. The entry at the stack pointer is always shown on the outputs through combinational logic, so the controller can test and compare the current range in the same cycle it needs it.

The controller can change the top entry in two ways. It can rewrite any subset of its three fields in place, using one strobe per field, which is how a range is shrunk after partitioning or how a pivot position is recorded. It can also push a complete new entry into the slot above the top. A pop discards the top entry and exposes the one below it. The depth is one slot more than the index width. When the engine always recurses into the smaller partition, that depth is enough for every case, so the block has no overflow handling beyond assertions.

Top module: `range_stack`

## Requirements
- R1: After reset the pointer is zero, every slot holds zero in all three fields, the three top outputs read zero and `empty` is high.
- R2: The top outputs always show the slot at the current pointer. In a cycle with no strobe, no push and no pop they do not change, and field values presented without a strobe are not stored.
- R3: With `push` low, each field strobe (`set_lo`, `set_hi`, `set_piv`) writes its own field of the top entry at the clock edge. The other fields of that entry keep their values.
- R4: With `push` high, all three input values are written into the slot at pointer+1 and the pointer increments. The new values appear on the top outputs after that edge. Push and pop in the same cycle is illegal; if it happens, push takes priority.
- R5: During a push the field strobes are ignored. The entry that was on top before the push keeps all its fields, which can be seen after a later pop.
- R6: A pop (with `push` low) decrements the pointer. The entry below reappears on the outputs with the contents it had before it was covered.
- R7: `empty` is high exactly when the pointer is zero, meaning only slot 0 remains. It goes low after a push and high again after the pop that returns the pointer to zero.
- R8: The stack has IDX_W+1 slots: slot 0 plus IDX_W pushes, with a pointer of ceil(log2(IDX_W+1)) bits. A full stack keeps every pushed entry intact until it is popped. Pushing when full and popping when empty are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Write all three field inputs into the slot above the top and move the pointer up |
| pop | input | 1 | Move the pointer down, discarding the top entry |
| set_lo | input | 1 | Rewrite the low field of the top entry (when push is low) |
| set_hi | input | 1 | Rewrite the high field of the top entry (when push is low) |
| set_piv | input | 1 | Rewrite the pivot field of the top entry (when push is low) |
| in_lo | input | IDX_W | Low bound value to write |
| in_hi | input | IDX_W | High bound value to write |
| in_piv | input | IDX_W | Pivot position value to write |
| top_lo | output | IDX_W | Low bound of the entry at the pointer |
| top_hi | output | IDX_W | High bound of the entry at the pointer |
| top_piv | output | IDX_W | Pivot position of the entry at the pointer |
| empty | output | 1 | High when the pointer is zero |

## Verification
The bench drives a push with all three strobes raised and then pops back. A design that honoured the strobes during a push would corrupt the covered entry, and the pop would expose the wrong values. It writes each field alone, which catches a shared write enable that clobbers its neighbours. It presents values without any strobe, which catches a write path that ignores the strobes altogether. It fills the stack to its full depth and unwinds it, which catches an off-by-one pushed-slot address or a too-narrow pointer: either would make a deep entry come back wrong or make `empty` rise at the wrong level. Finally it pushes again over a slot that was freed earlier, to show that stale contents are replaced.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Field lanes of one stack entry; the lane index selects strobe and data.
    typedef enum int {
        FLD_LO  = 0,
        FLD_HI  = 1,
        FLD_PIV = 2
    } rstk_field_e;

    localparam int NUM_FIELDS = 3;

    // Slots needed for a given index width: root slot plus one per halving.
    function automatic int stack_depth(input int idx_w);
        return idx_w + 1;
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
    parameter int DEPTH = 5,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [PTR_W-1:0] wr_addr_o,
    output logic             empty_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end else if (pop_i) begin
            st_d.ptr = st_q.ptr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o     = st_q.ptr;
    assign wr_addr_o = push_i ? st_q.ptr + 1'b1 : st_q.ptr;
    assign empty_o   = (st_q.ptr == '0);

    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R4

    AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (ptr_o == $past(ptr_o) + 1'b1)); // R4

    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (ptr_o == $past(ptr_o) - 1'b1)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (ptr_o != PTR_W'(DEPTH - 1))); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R8

    AST_EMPTY_AFTER_LAST_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && ptr_o == PTR_W'(1)) |=> empty_o); // R7

    AST_PUSH_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> !empty_o); // R7

endmodule

// File: rtl/rstk_field_bank.sv
module rstk_field_bank #(
    parameter int IDX_W = 4,
    parameter int DEPTH = 5,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             set_i,
    input  logic [PTR_W-1:0] wr_addr_i,
    input  logic [PTR_W-1:0] rd_addr_i,
    input  logic [IDX_W-1:0] wdata_i,
    output logic [IDX_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] slot;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        wr_en;

    assign wr_en = push_i || set_i;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_addr_i) < DEPTH)) begin
            st_d.slot[wr_addr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(rd_addr_i) < DEPTH) begin
            rdata_o = st_q.slot[rd_addr_i];
        end
    end

    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (rdata_o == $past(wdata_i))); // R4

    AST_FIELD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !push_i) ##1 $stable(rd_addr_i) |-> (rdata_o == $past(wdata_i))); // R3

    AST_FIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !push_i) ##1 $stable(rd_addr_i) |-> $stable(rdata_o)); // R2

endmodule

// File: rtl/range_stack.sv
module range_stack #(
    parameter int IDX_W = 4,
    localparam int DEPTH = rstk_pkg::stack_depth(IDX_W),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             set_lo,
    input  logic             set_hi,
    input  logic             set_piv,
    input  logic [IDX_W-1:0] in_lo,
    input  logic [IDX_W-1:0] in_hi,
    input  logic [IDX_W-1:0] in_piv,
    output logic [IDX_W-1:0] top_lo,
    output logic [IDX_W-1:0] top_hi,
    output logic [IDX_W-1:0] top_piv,
    output logic             empty
);

    import rstk_pkg::*;

    logic [PTR_W-1:0]                  ptr;
    logic [PTR_W-1:0]                  wr_addr;
    logic [NUM_FIELDS-1:0]             fld_set;
    logic [NUM_FIELDS-1:0][IDX_W-1:0]  fld_wdata;
    logic [NUM_FIELDS-1:0][IDX_W-1:0]  fld_rdata;

    assign fld_set[FLD_LO]    = set_lo;
    assign fld_set[FLD_HI]    = set_hi;
    assign fld_set[FLD_PIV]   = set_piv;
    assign fld_wdata[FLD_LO]  = in_lo;
    assign fld_wdata[FLD_HI]  = in_hi;
    assign fld_wdata[FLD_PIV] = in_piv;

    rstk_ptr #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .pop_i     (pop),
        .ptr_o     (ptr),
        .wr_addr_o (wr_addr),
        .empty_o   (empty)
    );

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        rstk_field_bank #(
            .IDX_W (IDX_W),
            .DEPTH (DEPTH),
            .PTR_W (PTR_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_i    (push),
            .set_i     (fld_set[f]),
            .wr_addr_i (wr_addr),
            .rd_addr_i (ptr),
            .wdata_i   (fld_wdata[f]),
            .rdata_o   (fld_rdata[f])
        );
    end

    assign top_lo  = fld_rdata[FLD_LO];
    assign top_hi  = fld_rdata[FLD_HI];
    assign top_piv = fld_rdata[FLD_PIV];

    AST_POP_KEEPS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !empty) ##1 pop |=> (top_lo == $past(top_lo, 2)
                                      && top_hi == $past(top_hi, 2)
                                      && top_piv == $past(top_piv, 2))); // R5

endmodule

// File: tb/test_range_stack.sv
`timescale 1ns/1ps
module test_range_stack;

    localparam int IDX_W = 4;
    localparam int DEPTH = IDX_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             push = 1'b0, pop = 1'b0;
    logic             set_lo = 1'b0, set_hi = 1'b0, set_piv = 1'b0;
    logic [IDX_W-1:0] in_lo = '0, in_hi = '0, in_piv = '0;
    logic [IDX_W-1:0] top_lo, top_hi, top_piv;
    logic             empty;

    always #4 clk = ~clk;

    range_stack #(.IDX_W(IDX_W)) i_range_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .set_lo(set_lo), .set_hi(set_hi), .set_piv(set_piv),
        .in_lo(in_lo), .in_hi(in_hi), .in_piv(in_piv),
        .top_lo(top_lo), .top_hi(top_hi), .top_piv(top_piv), .empty(empty)
    );

    typedef struct {
        logic [IDX_W-1:0] lo, hi, piv;
        logic             emp;
        string            tag;
    } exp_t;

    exp_t sb_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    logic [IDX_W-1:0] m_lo [DEPTH];
    logic [IDX_W-1:0] m_hi [DEPTH];
    logic [IDX_W-1:0] m_piv[DEPTH];
    int               m_ptr = 0;

    task automatic expect_top(input string tag);
        exp_t e;
        e.lo  = m_lo[m_ptr];
        e.hi  = m_hi[m_ptr];
        e.piv = m_piv[m_ptr];
        e.emp = (m_ptr == 0);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Drive one operation for one edge; strobe bits: [0]=low, [1]=high, [2]=pivot.
    task automatic step(input bit do_push, input bit do_pop, input logic [2:0] st,
                        input int lo, input int hi, input int pv, input string tag);
        @(negedge clk);
        push = do_push; pop = do_pop;
        set_lo = st[0]; set_hi = st[1]; set_piv = st[2];
        in_lo = IDX_W'(lo); in_hi = IDX_W'(hi); in_piv = IDX_W'(pv);
        if (do_push) begin
            m_ptr++;
            m_lo[m_ptr] = IDX_W'(lo); m_hi[m_ptr] = IDX_W'(hi); m_piv[m_ptr] = IDX_W'(pv);
        end else begin
            if (st[0]) m_lo[m_ptr]  = IDX_W'(lo);
            if (st[1]) m_hi[m_ptr]  = IDX_W'(hi);
            if (st[2]) m_piv[m_ptr] = IDX_W'(pv);
            if (do_pop) m_ptr--;
        end
        @(posedge clk);
        expect_top(tag);
        #1;
        push = 1'b0; pop = 1'b0; set_lo = 1'b0; set_hi = 1'b0; set_piv = 1'b0;
    endtask

    // Monitor: compare one expected top entry per falling edge.
    always @(negedge clk) begin : monitor
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_cmp++;
            if (top_lo !== e.lo || top_hi !== e.hi || top_piv !== e.piv || empty !== e.emp) begin
                n_bad++;
                $display("FAIL %s: got lo=%0d hi=%0d piv=%0d empty=%0b, expected lo=%0d hi=%0d piv=%0d empty=%0b",
                         e.tag, top_lo, top_hi, top_piv, empty, e.lo, e.hi, e.piv, e.emp);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (R1..R8 run): got no completion after 20000 cycles, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < DEPTH; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_piv[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_top("R1 reset state");

        step(0, 0, 3'b001, 3, 0, 0, "R3 low strobe alone");
        step(0, 0, 3'b010, 0, 9, 0, "R3 high strobe alone");
        step(0, 0, 3'b100, 0, 0, 5, "R3 pivot strobe alone");
        step(0, 0, 3'b000, 1, 2, 3, "R2 values without strobe not stored");
        step(0, 0, 3'b000, 0, 0, 0, "R2 idle cycle holds top");

        step(1, 0, 3'b111, 2, 7, 4, "R4 push with strobes raised, R7 empty falls");
        step(0, 0, 3'b011, 6, 8, 0, "R3 two strobes on pushed entry");
        step(0, 1, 3'b000, 0, 0, 0, "R5 pop shows slot 0 untouched by push, R7 empty rises");

        for (int k = 1; k <= IDX_W; k++) begin
            step(1, 0, 3'(k), k, k + 8, k + 4, "R8 push toward full depth");
        end
        step(0, 0, 3'b100, 0, 0, 15, "R3 pivot strobe at full depth");
        for (int k = IDX_W; k >= 1; k--) begin
            step(0, 1, 3'b000, 0, 0, 0, (k == 1) ? "R7 last pop sets empty" : "R6 pop exposes entry below");
        end

        step(1, 0, 3'b000, 11, 13, 12, "R4 push overwrites stale slot 1");
        step(0, 1, 3'b000, 0, 0, 0, "R6 pop back to root entry");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule